// File: doc/BRIEF.md
# Sequential Page Program Order Checker

This block watches program requests sent to a flash array built from blocks of 64 pages. Inside a block, the pages may only be written in ascending order, starting at the lowest page and moving up one page at a time. Writing to a page in any other order inside a block is random-page programming, and the block flags it. For every block the checker keeps a next-page pointer in a small register array. Each program launch is compared with the pointer of its block, and the checker answers one cycle later with either an accept pulse or a violation pulse. Both answers also report the page number the block expected.

A block erase strobe sets the pointer of the named block back to page 0. When page 63 of a block has been written, the block is full. The expected page then reads as 64, and every further program to that block is a violation until the block is erased. A rejected program leaves the pointer unchanged. The checker does not look at data content, and it does not model the program algorithm.

Top module: `page_order_checker`

## Requirements
- R1: After reset, every block pointer is 0. `accept` and `violation` are low, `exp_page` is 0, and the first program of page 0 to any block is accepted.
- R2: The first program in a block, counted from reset or from an erase, must target page 0. Any other page raises `violation` with `exp_page` = 0.
- R3: Once page N (N < 63) of a block has been accepted, a program of page N+1 to the same block is accepted, and `exp_page` reports N+1.
- R4: A program to a page other than the expected one raises `violation`, and `exp_page` reports the expected page. This covers a skipped page, a repeated page and a lower page.
- R5: A rejected program does not advance the pointer of its block. The expected page stays the same for the next launch.
- R6: After page 63 of a block is accepted, the block is full. Every later program to it raises `violation` with `exp_page` = 64 (bit 6 set) until the block is erased.
- R7: An erase strobe sets the pointer of the named block to 0, so the next program to that block must target page 0.
- R8: Each program strobe produces exactly one of `accept` or `violation`. The pulse is high for a single cycle, in the cycle after the strobe. Neither pulse rises in a cycle with no strobe.
- R9: When an erase and a program to the same block arrive in the same cycle, the erase takes effect first. The program is then checked against page 0, and if it is accepted the pointer ends at 1.
- R10: Each block has its own pointer. A program or erase of one block leaves the expected page of every other block unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_valid | input | 1 | Program launch strobe |
| prog_block | input | BLK_W | Block index of the program |
| prog_page | input | PG_W | Page index of the program |
| erase_valid | input | 1 | Block erase strobe |
| erase_block | input | BLK_W | Block index of the erase |
| accept | output | 1 | Single-cycle pulse: the program was in order |
| violation | output | 1 | Single-cycle pulse: the program was out of order or the block was full |
| exp_page | output | PG_W+1 | Page the block expected; 64 means full |

## Verification
A program launch and an erase strobe can arrive in the same cycle. The bench drives both strobes in the same cycle, once naming the same block and once naming different blocks. When they name the same block, a program of page 0 must be accepted even though the pointer had moved on. A following program of page 1 must also be accepted, which shows that the pointer ended at 1. When the strobes name different blocks, the program is judged against its own pointer. The bench then checks that the erased block expects page 0 again.

// File: rtl/page_order_checker.sv
module page_order_checker #(
  parameter int BLK_W = 4,
  parameter int PG_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_valid,
  input  logic [BLK_W-1:0] prog_block,
  input  logic [PG_W-1:0]  prog_page,
  input  logic             erase_valid,
  input  logic [BLK_W-1:0] erase_block,
  output logic             accept,
  output logic             violation,
  output logic [PG_W:0]    exp_page
);
  localparam int NBLK = 1 << BLK_W;
  localparam int PW   = PG_W + 1;

  logic [PW-1:0] ptr [NBLK];

  wire           same_blk = erase_valid && (erase_block == prog_block);
  wire [PW-1:0]  eff      = same_blk ? '0 : ptr[prog_block];
  wire           in_order = !eff[PG_W] && (eff[PG_W-1:0] == prog_page);
  wire           take     = prog_valid && in_order;
  wire [PW-1:0]  eff_inc  = eff + PW'(1);

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    wire prog_hit  = take && (prog_block == BLK_W'(b));
    wire erase_hit = erase_valid && (erase_block == BLK_W'(b));
    always_ff @(posedge clk) begin
      if (!rst_n)         ptr[b] <= '0;
      else if (prog_hit)  ptr[b] <= eff_inc;
      else if (erase_hit) ptr[b] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accept    <= 1'b0;
      violation <= 1'b0;
      exp_page  <= '0;
    end else begin
      accept    <= take;
      violation <= prog_valid && !in_order;
      if (prog_valid) exp_page <= eff;
    end
  end
endmodule

module page_order_checker_sva #(
  parameter int BLK_W = 4,
  parameter int PG_W  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prog_valid,
  input logic [BLK_W-1:0] prog_block,
  input logic [PG_W-1:0]  prog_page,
  input logic             accept,
  input logic             violation,
  input logic [PG_W:0]    exp_page
);
  // R8
  one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_valid |=> (accept ^ violation));
  // R8
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_valid |=> !(accept || violation));
  // R3
  accept_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (exp_page == {1'b0, $past(prog_page)}));
  // R4
  violation_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    violation |-> (exp_page != {1'b0, $past(prog_page)}));
  // R6
  full_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !exp_page[PG_W]);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !(accept || violation));
endmodule

bind page_order_checker page_order_checker_sva #(.BLK_W(BLK_W), .PG_W(PG_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .prog_valid(prog_valid), .prog_block(prog_block),
  .prog_page(prog_page), .accept(accept), .violation(violation), .exp_page(exp_page)
);

// File: tb/page_order_checker_test.sv
module page_order_checker_test;
  localparam int CLK_PERIOD = 10;
  localparam int BLK_W = 4;
  localparam int PG_W  = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             prog_valid = 1'b0;
  logic [BLK_W-1:0] prog_block = '0;
  logic [PG_W-1:0]  prog_page = '0;
  logic             erase_valid = 1'b0;
  logic [BLK_W-1:0] erase_block = '0;
  logic             accept, violation;
  logic [PG_W:0]    exp_page;

  int checks = 0;
  int fails  = 0;

  page_order_checker #(.BLK_W(BLK_W), .PG_W(PG_W)) uut (
    .clk(clk), .rst_n(rst_n), .prog_valid(prog_valid), .prog_block(prog_block),
    .prog_page(prog_page), .erase_valid(erase_valid), .erase_block(erase_block),
    .accept(accept), .violation(violation), .exp_page(exp_page)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic acc, input logic vio,
                       input int pg, input logic want_acc, input int want_pg);
    checks++;
    if (acc !== want_acc || vio !== !want_acc || pg != want_pg) begin
      fails++;
      $display("FAIL %s: accept=%0b violation=%0b exp_page=%0d, expected accept=%0b violation=%0b exp_page=%0d",
               req, acc, vio, pg, want_acc, !want_acc, want_pg);
    end
  endtask

  // Drive one cycle of strobes, then sample the registered answer.
  task automatic step(input logic pv, input int pb, input int pp,
                      input logic ev, input int eb);
    @(negedge clk);
    prog_valid  = pv;  prog_block  = BLK_W'(pb); prog_page = PG_W'(pp);
    erase_valid = ev;  erase_block = BLK_W'(eb);
    @(negedge clk);
    prog_valid = 1'b0; erase_valid = 1'b0;
  endtask

  task automatic prog(input string req, input int b, input int p,
                      input logic want_acc, input int want_pg);
    step(1'b1, b, p, 1'b0, 0);
    check(req, accept, violation, int'(exp_page), want_acc, want_pg);
  endtask

  task automatic erase(input int b);
    step(1'b0, 0, 0, 1'b1, b);
  endtask

  task automatic t_reset;
    checks++;
    if (accept !== 1'b0 || violation !== 1'b0 || exp_page !== '0) begin
      fails++;
      $display("FAIL R1: accept=%0b violation=%0b exp_page=%0d, expected 0 0 0",
               accept, violation, exp_page);
    end
    prog("R1", 9, 0, 1'b1, 0);
  endtask

  task automatic t_first_page;
    prog("R2", 3, 5, 1'b0, 0);
    prog("R2", 3, 0, 1'b1, 0);
  endtask

  task automatic t_fill_block;
    for (int p = 1; p < 64; p++) prog("R3", 3, p, 1'b1, p);
    prog("R6", 3, 0, 1'b0, 64);
    prog("R6", 3, 63, 1'b0, 64);
  endtask

  task automatic t_out_of_order;
    prog("R2", 5, 0, 1'b1, 0);
    prog("R4", 5, 2, 1'b0, 1);
    prog("R4", 5, 0, 1'b0, 1);
    prog("R5", 5, 1, 1'b1, 1);
    prog("R4", 5, 1, 1'b0, 2);
    prog("R5", 5, 2, 1'b1, 2);
  endtask

  task automatic t_erase;
    erase(3);
    prog("R7", 3, 1, 1'b0, 0);
    prog("R7", 3, 0, 1'b1, 0);
    prog("R10", 5, 3, 1'b1, 3);
    prog("R10", 9, 1, 1'b1, 1);
  endtask

  task automatic t_same_cycle;
    step(1'b1, 5, 0, 1'b1, 5);
    check("R9", accept, violation, int'(exp_page), 1'b1, 0);
    prog("R9", 5, 1, 1'b1, 1);
    step(1'b1, 9, 2, 1'b1, 3);
    check("R9", accept, violation, int'(exp_page), 1'b1, 2);
    prog("R10", 3, 0, 1'b1, 0);
  endtask

  task automatic t_pulse;
    step(1'b1, 7, 4, 1'b0, 0);
    check("R8", accept, violation, int'(exp_page), 1'b0, 0);
    @(negedge clk);
    checks++;
    if (accept !== 1'b0 || violation !== 1'b0) begin
      fails++;
      $display("FAIL R8: accept=%0b violation=%0b one cycle later, expected 0 0",
               accept, violation);
    end
    prog("R8", 7, 0, 1'b1, 0);
    @(negedge clk);
    checks++;
    if (accept !== 1'b0 || violation !== 1'b0) begin
      fails++;
      $display("FAIL R8: accept=%0b violation=%0b one cycle later, expected 0 0",
               accept, violation);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_first_page;
    t_fill_block;
    t_out_of_order;
    t_erase;
    t_same_cycle;
    t_pulse;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule